// File: doc/BRIEF.md
# Seven-to-One Parallel Display Link Serializer

This block takes one 28-bit pixel word per pixel period and sends it out over four one-bit lanes, seven bits per lane per word. A fifth lane carries a fixed clock pattern so that the far end can recover word boundaries. Everything runs on a fast clock at seven times the pixel rate. The pixel-rate strobe is sampled in the fast domain, and its selected edge marks when the parallel word is captured.

A small controller has three states. `ST_OFF` is entered on reset and whenever `shut_n` is low. `ST_WAIT` is entered when `shut_n` is high and no word has yet been captured. `ST_RUN` is entered on the first capture. The transitions are:

- OFF→WAIT when `shut_n` is high.
- WAIT→RUN on a capture pulse, which also clears the slot counter to 0.
- RUN→RUN, stepping the slot counter from 0 to 6 and wrapping.
- WAIT→OFF and RUN→OFF when `shut_n` goes low.

In `ST_RUN` the lane shift registers load the held word at the edge where the slot counter is 6. They then shift once per fast clock until the next load.

Top module: `pix_ser7_top`

## Requirements
- R1: While `rst_n` is low, `lane_out` and `clk_lane` are 0.
- R2: Lanes carry fixed input bits, listed here in slot order 0..6. Lane 0 carries bits 0,1,2,3,4,6,7. Lane 1 carries 8,9,12,13,14,15,18. Lane 2 carries 19,20,21,22,24,25,26. Lane 3 carries 27,5,10,11,16,17,23.
- R3: Each word is sent as seven consecutive fast-clock slots, one bit per lane per slot, in the slot order of R2.
- R4: Over slots 0..6, `clk_lane` outputs 1,1,0,0,0,1,1, with slot 0 aligned to data slot 0. It is therefore high for 4 of the 7 slots.
- R5: When `edge_sel`=1 the word is captured on a rising `pix_strobe` edge. When `edge_sel`=0 it is captured on a falling edge. The opposite edge is ignored.
- R6: Suppose a capturing strobe transition and its data are applied between fast edges n and n+1. Slot k of that word then appears just after edge n+10+k.
- R7: While `shut_n` is low, all outputs are 0 from the first edge after it falls, and strobe activity has no effect on them.
- R8: After reset or shutdown ends, the first capture starts the slot counter at 0. The outputs stay 0 until that word has been loaded.
- R9: Words whose capture edges come every 7 fast clocks are sent back to back, with no gap or repeated slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Serial-rate clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_data | input | 28 | Parallel pixel word, held stable for one pixel period |
| pix_strobe | input | 1 | Pixel-rate strobe, sampled in the fast domain |
| edge_sel | input | 1 | 1: capture on rising strobe edge, 0: capture on falling edge |
| shut_n | input | 1 | Active-low shutdown |
| lane_out | output | 4 | Serial data lanes, bit i is lane i |
| clk_lane | output | 1 | Serial clock-pattern lane |

## Verification
A capturing strobe transition takes three fast edges to become a capture: two synchronizer stages and one capture register. The word is then loaded seven edges later, so slot k of that word is due ten plus k edges after the transition. Shutdown clears the outputs at the very next edge. The bench counts fast-clock falling edges from the moment it drives each word. It compares every slot at the falling edge that follows the edge on which that slot is due, and it checks for zeros on each falling edge in the gap before the first load.

// File: rtl/pix_ser7_pkg.sv
package pix_ser7_pkg;

    localparam int unsigned LANES_DEF = 4;
    localparam int unsigned SLOTS_DEF = 7;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } ser_state_e;

    // Source bit of the parallel word for lane l, slot k: index l*SLOTS_DEF + k.
    localparam int unsigned LANE_SRC [LANES_DEF*SLOTS_DEF] = '{
        0, 1, 2, 3, 4, 6, 7,
        8, 9, 12, 13, 14, 15, 18,
        19, 20, 21, 22, 24, 25, 26,
        27, 5, 10, 11, 16, 17, 23
    };

    // Clock lane level for slot k is bit k.
    localparam logic [SLOTS_DEF-1:0] CLK_PAT = 7'b1100011;

endpackage

// File: rtl/pix_ser7_edge.sv
module pix_ser7_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    input  logic edge_sel,
    output logic cap_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign cur = sync_q[SYNC_STAGES-1];

    always_comb begin
        if (edge_sel) begin
            cap_o = cur & ~prev_q;
        end else begin
            cap_o = ~cur & prev_q;
        end
    end

endmodule

// File: rtl/pix_ser7_ctrl.sv
module pix_ser7_ctrl
    import pix_ser7_pkg::*;
#(
    parameter int unsigned SLOTS = 7,
    localparam int unsigned PH_W = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shut_n,
    input  logic            cap_i,
    output ser_state_e      state_o,
    output logic [PH_W-1:0] phase_o,
    output logic            load_o,
    output logic            clr_o,
    output logic            take_o
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOTS - 1);

    ser_state_e      state_q, state_d;
    logic [PH_W-1:0] phase_q, phase_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // Next state and slot counter
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        unique case (state_q)
            ST_OFF: begin
                phase_d = '0;
                if (shut_n) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                phase_d = '0;
                if (!shut_n) begin
                    state_d = ST_OFF;
                end else if (cap_i) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!shut_n) begin
                    state_d = ST_OFF;
                    phase_d = '0;
                end else if (phase_q == PH_LAST) begin
                    phase_d = '0;
                end else begin
                    phase_d = phase_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_OFF;
                phase_d = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        load_o = (state_q == ST_RUN) && (phase_q == PH_LAST);
        clr_o  = !shut_n || (state_q != ST_RUN);
        take_o = shut_n && cap_i && (state_q != ST_OFF);
    end

    assign state_o = state_q;
    assign phase_o = phase_q;

endmodule

// File: rtl/pix_ser7_shift.sv
module pix_ser7_shift #(
    parameter int unsigned SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [SLOTS-1:0] par_in,
    output logic             ser_o
);

    logic [SLOTS-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clr) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= par_in;
        end else begin
            sh_q <= {1'b0, sh_q[SLOTS-1:1]};
        end
    end

    assign ser_o = sh_q[0];

endmodule

// File: rtl/pix_ser7_top.sv
module pix_ser7_top
    import pix_ser7_pkg::*;
#(
    parameter int unsigned LANES       = LANES_DEF,
    parameter int unsigned SLOTS       = SLOTS_DEF,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk_fast,
    input  logic                   rst_n,
    input  logic [LANES*SLOTS-1:0] pix_data,
    input  logic                   pix_strobe,
    input  logic                   edge_sel,
    input  logic                   shut_n,
    output logic [LANES-1:0]       lane_out,
    output logic                   clk_lane
);

    localparam int unsigned DATA_W = LANES * SLOTS;
    localparam int unsigned PH_W   = $clog2(SLOTS);

    logic              cap;
    logic              load;
    logic              clr;
    logic              take;
    ser_state_e        state;
    logic [PH_W-1:0]   phase;
    logic [DATA_W-1:0] word_hold;

    pix_ser7_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk       (clk_fast),
        .rst_n     (rst_n),
        .strobe_in (pix_strobe),
        .edge_sel  (edge_sel),
        .cap_o     (cap)
    );

    pix_ser7_ctrl #(.SLOTS(SLOTS)) ctrl_i (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .shut_n  (shut_n),
        .cap_i   (cap),
        .state_o (state),
        .phase_o (phase),
        .load_o  (load),
        .clr_o   (clr),
        .take_o  (take)
    );

    // First register stage: word held from its capture edge to its load edge.
    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            word_hold <= '0;
        end else if (take) begin
            word_hold <= pix_data;
        end
    end

    // Second register stage: one shift register per data lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SLOTS-1:0] lane_par;
        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            assign lane_par[k] = word_hold[LANE_SRC[l*SLOTS+k]];
        end
        pix_ser7_shift #(.SLOTS(SLOTS)) shift_i (
            .clk    (clk_fast),
            .rst_n  (rst_n),
            .clr    (clr),
            .load   (load),
            .par_in (lane_par),
            .ser_o  (lane_out[l])
        );
    end

    pix_ser7_shift #(.SLOTS(SLOTS)) clk_shift_i (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .clr    (clr),
        .load   (load),
        .par_in (CLK_PAT[SLOTS-1:0]),
        .ser_o  (clk_lane)
    );

endmodule

// File: rtl/pix_ser7_chk.sv
module pix_ser7_chk
    import pix_ser7_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned SLOTS = 7,
    localparam int unsigned PH_W = $clog2(SLOTS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shut_n,
    input logic             cap,
    input logic             load,
    input ser_state_e       state,
    input logic [PH_W-1:0]  phase,
    input logic [LANES-1:0] lane_out,
    input logic             clk_lane
);

    assert_quiet_in_shutdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shut_n |=> (lane_out == '0 && !clk_lane));

    assert_restart_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && shut_n && cap) |=> (state == ST_RUN && phase == '0 && lane_out == '0 && !clk_lane));

    assert_wait_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (lane_out == '0 && !clk_lane));

    assert_clk_slot0_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && shut_n) |=> clk_lane);

    assert_clk_slot2_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && shut_n && phase == PH_W'(1)) |=> !clk_lane);

    assert_phase_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PH_W'(SLOTS - 1));

endmodule

bind pix_ser7_top pix_ser7_chk #(.LANES(LANES), .SLOTS(SLOTS)) chk_i (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .shut_n   (shut_n),
    .cap      (cap),
    .load     (load),
    .state    (state),
    .phase    (phase),
    .lane_out (lane_out),
    .clk_lane (clk_lane)
);

// File: tb/pix_ser7_tb.sv
`timescale 1ns/1ps
module pix_ser7_top_tb_top;

    localparam int NV = 6;
    localparam logic [27:0] VEC [NV] = '{
        28'h0000001, 28'hFFFFFFF, 28'hA5C3E17,
        28'h5A3C1E8, 28'h8000020, 28'h1234567
    };
    // Expected source bit per lane (row) and slot (column), written from R2.
    localparam int MAP [28] = '{
        0, 1, 2, 3, 4, 6, 7,
        8, 9, 12, 13, 14, 15, 18,
        19, 20, 21, 22, 24, 25, 26,
        27, 5, 10, 11, 16, 17, 23
    };
    localparam logic [6:0] PAT = 7'b1100011;

    logic        clk_fast = 1'b0;
    logic        rst_n;
    logic [27:0] pix_data;
    logic        pix_strobe;
    logic        edge_sel;
    logic        shut_n;
    logic [3:0]  lane_out;
    logic        clk_lane;

    int checks = 0;
    int fails  = 0;

    always #4 clk_fast = ~clk_fast;

    pix_ser7_top dut_i (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .pix_data   (pix_data),
        .pix_strobe (pix_strobe),
        .edge_sel   (edge_sel),
        .shut_n     (shut_n),
        .lane_out   (lane_out),
        .clk_lane   (clk_lane)
    );

    task automatic check(input string req, input logic [4:0] exp);
        checks++;
        if ({clk_lane, lane_out} !== exp) begin
            fails++;
            $display("FAIL %s at %0t: got clk=%b lanes=%b, expected clk=%b lanes=%b",
                     req, $time, clk_lane, lane_out, exp[4], exp[3:0]);
        end
    endtask

    function automatic logic [4:0] expect_slot(input logic [27:0] w, input int k);
        logic [4:0] e;
        for (int l = 0; l < 4; l++) e[l] = w[MAP[l*7+k]];
        e[4] = PAT[k];
        return e;
    endfunction

    // Drives the vector table in the given capture mode, starting from ST_WAIT.
    task automatic run_words(input logic mode, input string tag);
        for (int c = 0; c <= 7*(NV-1)+16; c++) begin
            @(negedge clk_fast);
            if (c >= 1 && c <= 9) begin
                check({"R8 quiet before first load ", tag}, 5'b0);
            end else if (c >= 10) begin
                int j = (c - 10) / 7;
                int k = (c - 10) % 7;
                if (j < NV) check({"R2 R3 R4 R6 R9 slot ", tag}, expect_slot(VEC[j], k));
            end
            if (c % 7 == 0 && c / 7 < NV) begin
                pix_data   = VEC[c/7];
                pix_strobe = mode;
            end else if (c % 7 == 3 && c / 7 < NV) begin
                pix_strobe = ~mode;
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        shut_n     = 1'b1;
        edge_sel   = 1'b1;
        pix_strobe = 1'b0;
        pix_data   = '0;
        repeat (3) @(negedge clk_fast);
        check("R1 reset outputs low", 5'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_fast);
        check("R8 idle after reset", 5'b0);

        // Rising-edge capture (R5 with edge_sel=1).
        run_words(1'b1, "R5 rising");

        // Shutdown: outputs go low at the next edge and ignore the strobe (R7).
        shut_n = 1'b0;
        @(negedge clk_fast);
        check("R7 shutdown clears outputs", 5'b0);
        for (int i = 0; i < 14; i++) begin
            if (i % 2 == 0) begin
                pix_strobe = ~pix_strobe;
                pix_data   = ~pix_data;
            end
            @(negedge clk_fast);
            check("R7 strobe ignored in shutdown", 5'b0);
        end
        pix_strobe = 1'b1;
        edge_sel   = 1'b0;
        repeat (3) @(negedge clk_fast);
        shut_n = 1'b1;
        repeat (3) @(negedge clk_fast);
        check("R8 idle after shutdown release", 5'b0);

        // Falling-edge capture (R5 with edge_sel=0); rising mid-word edge ignored.
        run_words(1'b0, "R5 falling");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule